// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block takes a single-rank SDRAM from power-up to normal operation and then keeps it refreshed. After reset it holds the command bus idle for a programmable power-up wait. It then issues a precharge of all banks, a mode register load, eight auto-refreshes and a second mode register load. The second load serves devices that only accept the mode after the refreshes.

Once the second mode load has gone out, the block starts its periodic refresh timer. It then opens row 0 and performs ten read-then-write accesses to columns 0 through 9 to let the device settle. After a final precharge of all banks it raises `ready`. From then on, each expiry of the refresh timer produces a group of four auto-refresh commands.

The timer period is a base count multiplied by a divider. A select input picks between a fast divider and a slow one that is twice as long. The slow divider suits smaller devices, whose size is known only after they have been probed. The minimum spacing after each command is set by parameters given in clock cycles.

Top module: `sdram_boot_sequencer`

## Requirements
- R1: While reset is high, the command bus carries NOP, the address bus is all zeros, and `ready` is low.
- R2: Only NOP appears on the command bus for at least PWRUP_CYCLES clock cycles after reset is released.
- R3: The first command is a precharge with address bit PRE_ALL_BIT set, which closes all banks. At least T_RP cycles later comes a mode register set whose address equals MODE_VALUE shifted left by MODE_SHIFT (0x22 << 2 = 0x088 by default).
- R4: At least T_MRD cycles after the first mode register set, exactly INIT_REFS (8) auto-refresh commands follow, each at least T_RFC cycles after the previous command.
- R5: At least T_RFC cycles after the last initial refresh, a second mode register set follows with the same address value as in R3.
- R6: At least T_MRD cycles after the second mode register set comes an activate to row 0 (address 0). WARMUP_ACCESSES (10) pairs then follow. Pair i is a read to column i and then a write to column i, for i = 0, 1, 2, … in order. Each read is separated from its write by at least CAS_LAT+1 cycles. After the activate and after each write, the next command waits at least T_RCD and T_WR cycles respectively. A precharge of all banks closes the sequence.
- R7: `ready` rises at least T_RP cycles after the closing precharge. It rises only when the refresh timer is already running, and it then stays high until reset.
- R8: After `ready` rises, refreshes are issued only in groups of BURST_REFS (4) back-to-back auto-refresh commands, spaced at least T_RFC apart. With `slow_refresh` low, successive groups start exactly REF_PERIOD*FAST_DIV cycles apart.
- R9: With `slow_refresh` high, successive refresh groups start exactly REF_PERIOD*SLOW_DIV cycles apart. The divider is sampled each time the timer reloads.
- R10: The command is encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode register set 0000. No other code is ever driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_refresh | input | 1 | Selects the slow refresh divider |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus: mode word, column, or all-bank flag |
| ready | output | 1 | Initialisation done; the device is usable |

## Verification
The assertions assume that every spacing parameter is at least 2. Under that assumption a refresh is always followed by a NOP cycle. They also assume that reset is held for at least one clock edge, so the power-up counter starts from a known point.

The stimulus holds reset for several cycles before each run. It keeps `slow_refresh` constant for the whole of a run, and the two divider settings are exercised in separate runs. This keeps the spacing between refresh groups free of the mixed interval that a mid-count change would produce.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_PRECHARGE,
        ST_MODE_FIRST,
        ST_INIT_REFRESH,
        ST_MODE_SECOND,
        ST_OPEN_ROW,
        ST_WARM_READ,
        ST_WARM_WRITE,
        ST_CLOSE_ROWS,
        ST_SETTLE,
        ST_READY,
        ST_BURST_REFRESH
    } seq_state_e;

    // One command slot: the command plus which address source it uses.
    typedef struct packed {
        sd_cmd_e cmd;
        logic    all_banks;
        logic    mode_word;
        logic    column;
    } cmd_slot_t;

    localparam cmd_slot_t IDLE_SLOT = '{cmd: CMD_NOP, all_banks: 1'b0,
                                        mode_word: 1'b0, column: 1'b0};

    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_wait_counter.sv
module sdram_wait_counter #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int PERIOD   = 195,
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic slow,
    output logic tick
);
    localparam int FAST_LIM = PERIOD * FAST_DIV - 1;
    localparam int SLOW_LIM = PERIOD * SLOW_DIV - 1;
    localparam int W        = $clog2(sdram_seq_pkg::larger(FAST_LIM, SLOW_LIM) + 1);

    logic [W-1:0] cnt;
    logic [W-1:0] reload;

    assign reload = slow ? W'(SLOW_LIM) : W'(FAST_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (!enable) begin
            cnt  <= reload;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= reload;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_seq_pkg::*;
#(
    parameter int PWRUP_CYCLES    = 10000,
    parameter int T_RP            = 2,
    parameter int T_RFC           = 4,
    parameter int T_MRD           = 2,
    parameter int T_RCD           = 2,
    parameter int CAS_LAT         = 2,
    parameter int T_WR            = 2,
    parameter int INIT_REFS       = 8,
    parameter int BURST_REFS      = 4,
    parameter int WARMUP_ACCESSES = 10,
    parameter int COL_W           = $clog2(WARMUP_ACCESSES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    output cmd_slot_t        slot,
    output logic [COL_W-1:0] column,
    output logic             refresh_en,
    output logic             ready
);
    localparam int GAP_MAX = larger(larger(larger(T_RP, T_RFC), larger(T_MRD, T_RCD)),
                                    larger(CAS_LAT + 1, T_WR));
    localparam int WAIT_W  = $clog2(larger(PWRUP_CYCLES, GAP_MAX) + 1);
    localparam int REF_W   = $clog2(larger(INIT_REFS, BURST_REFS) + 1);

    seq_state_e       state, nxt;
    logic [REF_W-1:0] ref_cnt, ref_nxt;
    logic [COL_W-1:0] acc, acc_nxt;
    logic             en_nxt, pend, take;
    logic             wt_done, wt_load;
    logic [WAIT_W-1:0] gap_m1;
    int               gap;

    sdram_wait_counter #(.W(WAIT_W), .RST_VAL(PWRUP_CYCLES)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .load  (wt_load),
        .value (gap_m1),
        .done  (wt_done)
    );

    always_comb begin
        slot    = IDLE_SLOT;
        nxt     = state;
        ref_nxt = ref_cnt;
        acc_nxt = acc;
        en_nxt  = refresh_en;
        take    = 1'b0;
        gap     = 1;
        unique case (state)
            ST_POWERUP: if (wt_done) nxt = ST_PRECHARGE;
            ST_PRECHARGE: if (wt_done) begin
                slot.cmd = CMD_PRE; slot.all_banks = 1'b1;
                gap = T_RP; nxt = ST_MODE_FIRST;
            end
            ST_MODE_FIRST: if (wt_done) begin
                slot.cmd = CMD_MRS; slot.mode_word = 1'b1;
                gap = T_MRD; nxt = ST_INIT_REFRESH; ref_nxt = '0;
            end
            ST_INIT_REFRESH: if (wt_done) begin
                slot.cmd = CMD_REF; gap = T_RFC;
                if (ref_cnt == REF_W'(INIT_REFS - 1)) begin
                    nxt = ST_MODE_SECOND; ref_nxt = '0;
                end else begin
                    ref_nxt = ref_cnt + 1'b1;
                end
            end
            ST_MODE_SECOND: if (wt_done) begin
                slot.cmd = CMD_MRS; slot.mode_word = 1'b1;
                gap = T_MRD; nxt = ST_OPEN_ROW; en_nxt = 1'b1;
            end
            ST_OPEN_ROW: if (wt_done) begin
                slot.cmd = CMD_ACT; gap = T_RCD;
                nxt = ST_WARM_READ; acc_nxt = '0;
            end
            ST_WARM_READ: if (wt_done) begin
                slot.cmd = CMD_RD; slot.column = 1'b1;
                gap = CAS_LAT + 1; nxt = ST_WARM_WRITE;
            end
            ST_WARM_WRITE: if (wt_done) begin
                slot.cmd = CMD_WR; slot.column = 1'b1; gap = T_WR;
                if (acc == COL_W'(WARMUP_ACCESSES - 1)) begin
                    nxt = ST_CLOSE_ROWS;
                end else begin
                    acc_nxt = acc + 1'b1; nxt = ST_WARM_READ;
                end
            end
            ST_CLOSE_ROWS: if (wt_done) begin
                slot.cmd = CMD_PRE; slot.all_banks = 1'b1;
                gap = T_RP; nxt = ST_SETTLE;
            end
            ST_SETTLE: if (wt_done) nxt = ST_READY;
            ST_READY: if (wt_done && pend) begin
                take = 1'b1; ref_nxt = '0; nxt = ST_BURST_REFRESH;
            end
            ST_BURST_REFRESH: if (wt_done) begin
                slot.cmd = CMD_REF; gap = T_RFC;
                if (ref_cnt == REF_W'(BURST_REFS - 1)) begin
                    nxt = ST_READY; ref_nxt = '0;
                end else begin
                    ref_nxt = ref_cnt + 1'b1;
                end
            end
            default: nxt = ST_POWERUP;
        endcase
        wt_load = (slot.cmd != CMD_NOP);
        gap_m1  = WAIT_W'(gap - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_POWERUP;
            ref_cnt    <= '0;
            acc        <= '0;
            refresh_en <= 1'b0;
            pend       <= 1'b0;
        end else begin
            state      <= nxt;
            ref_cnt    <= ref_nxt;
            acc        <= acc_nxt;
            refresh_en <= en_nxt;
            if (take)     pend <= 1'b0;
            if (ref_tick) pend <= 1'b1;
        end
    end

    assign column = acc;
    assign ready  = (state == ST_READY) || (state == ST_BURST_REFRESH);
endmodule

// File: rtl/sdram_boot_sequencer.sv
module sdram_boot_sequencer
    import sdram_seq_pkg::*;
#(
    parameter int PWRUP_CYCLES    = 10000,
    parameter int T_RP            = 2,
    parameter int T_RFC           = 4,
    parameter int T_MRD           = 2,
    parameter int T_RCD           = 2,
    parameter int CAS_LAT         = 2,
    parameter int T_WR            = 2,
    parameter int INIT_REFS       = 8,
    parameter int BURST_REFS      = 4,
    parameter int WARMUP_ACCESSES = 10,
    parameter int REF_PERIOD      = 195,
    parameter int FAST_DIV        = 8,
    parameter int SLOW_DIV        = 16,
    parameter int ADDR_W          = 13,
    parameter int MODE_VALUE      = 'h22,
    parameter int MODE_SHIFT      = 2,
    parameter int PRE_ALL_BIT     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_refresh,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              ready
);
    localparam int COL_W = $clog2(WARMUP_ACCESSES + 1);
    localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_VALUE) << MODE_SHIFT;

    cmd_slot_t        slot;
    logic [COL_W-1:0] column;
    logic             refresh_en;
    logic             ref_tick;

    sdram_refresh_timer #(
        .PERIOD(REF_PERIOD), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (refresh_en),
        .slow   (slow_refresh),
        .tick   (ref_tick)
    );

    sdram_init_fsm #(
        .PWRUP_CYCLES(PWRUP_CYCLES), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_WR(T_WR), .INIT_REFS(INIT_REFS),
        .BURST_REFS(BURST_REFS), .WARMUP_ACCESSES(WARMUP_ACCESSES), .COL_W(COL_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .slot       (slot),
        .column     (column),
        .refresh_en (refresh_en),
        .ready      (ready)
    );

    always_comb begin
        sd_addr = '0;
        if (slot.all_banks) sd_addr[PRE_ALL_BIT] = 1'b1;
        if (slot.mode_word) sd_addr = MODE_WORD;
        if (slot.column)    sd_addr = ADDR_W'(column);
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = slot.cmd;
endmodule

// File: rtl/sdram_boot_sequencer_checker.sv
module sdram_boot_sequencer_checker #(
    parameter int PWRUP_CYCLES = 10000,
    parameter int ADDR_W       = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0,
    parameter int PRE_ALL_BIT  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ready,
    input logic              refresh_en
);
    localparam int CW = $clog2(PWRUP_CYCLES + 2);

    logic [3:0]    cmd;
    logic [CW-1:0] since_rst;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != CW'(PWRUP_CYCLES))
            since_rst <= since_rst + 1'b1;
    end

    assert_pwrup_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(PWRUP_CYCLES)) |-> (cmd == 4'b0111));

    assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> addr[PRE_ALL_BIT]);

    assert_mode_word_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> (addr == MODE_WORD));

    assert_refresh_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001) |=> (cmd == 4'b0111));

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_ready_needs_timer_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> refresh_en);

    assert_legal_code_R10: assert property (@(posedge clk) disable iff (rst)
        cmd inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111});
endmodule

bind sdram_boot_sequencer sdram_boot_sequencer_checker #(
    .PWRUP_CYCLES(PWRUP_CYCLES), .ADDR_W(ADDR_W),
    .MODE_WORD(MODE_WORD), .PRE_ALL_BIT(PRE_ALL_BIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (sd_cs_n),
    .ras_n      (sd_ras_n),
    .cas_n      (sd_cas_n),
    .we_n       (sd_we_n),
    .addr       (sd_addr),
    .ready      (ready),
    .refresh_en (refresh_en)
);

// File: tb/sdram_boot_sequencer_test.sv
module sdram_boot_sequencer_test;
    localparam int PWRUP  = 50;
    localparam int T_RP   = 2;
    localparam int T_RFC  = 4;
    localparam int T_MRD  = 2;
    localparam int T_RCD  = 2;
    localparam int CAS    = 2;
    localparam int T_WR   = 2;
    localparam int PERIOD = 10;
    localparam int FDIV   = 4;
    localparam int SDIV   = 8;
    localparam int AW     = 13;
    localparam int MODEW  = 'h22 << 2;
    localparam int LOGN   = 96;

    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                           PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slow_refresh = 1'b0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready;
    logic [AW-1:0] sd_addr;
    logic [3:0] cmd_now;

    always #10 clk = ~clk;

    sdram_boot_sequencer #(
        .PWRUP_CYCLES(PWRUP), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .T_RCD(T_RCD), .CAS_LAT(CAS), .T_WR(T_WR), .REF_PERIOD(PERIOD),
        .FAST_DIV(FDIV), .SLOW_DIV(SDIV), .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst(rst), .slow_refresh(slow_refresh),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .ready(ready)
    );

    assign cmd_now = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit logging = 1'b0;
    int log_cnt;
    int ready_t;
    int ready_drop;
    logic [3:0]    log_cmd  [LOGN];
    logic [AW-1:0] log_addr [LOGN];
    int            log_t    [LOGN];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (logging) begin
            if (cmd_now != NOP && log_cnt < LOGN) begin
                log_cmd[log_cnt]  = cmd_now;
                log_addr[log_cnt] = sd_addr;
                log_t[log_cnt]    = cyc;
                log_cnt++;
            end
            if (ready && ready_t < 0) ready_t = cyc;
            if (!ready && ready_t >= 0) ready_drop++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_phase(input bit slow);
        int interval;
        int idx;
        interval = PERIOD * (slow ? SDIV : FDIV);
        slow_refresh = slow;
        rst = 1'b1;
        log_cnt = 0; ready_t = -1; ready_drop = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cmd_now == NOP, "R1 cmd", int'(cmd_now), int'(NOP));
        check(sd_addr == '0, "R1 addr", int'(sd_addr), 0);
        check(ready == 1'b0, "R1 ready", int'(ready), 0);
        rst = 1'b0;
        logging = 1'b1;
        repeat (700) @(posedge clk);
        @(negedge clk);
        logging = 1'b0;

        check(log_cnt >= 49, "R8 enough commands", log_cnt, 49);
        if (log_cnt < 49) return;
        // R2 / R3
        check(log_t[0] >= PWRUP, "R2 power-up wait", log_t[0], PWRUP);
        check(log_cmd[0] == PRE && log_addr[0][10], "R3 first precharge-all",
              int'(log_cmd[0]), int'(PRE));
        check(log_cmd[1] == MRS && log_addr[1] == AW'(MODEW), "R3 first mode set",
              int'(log_addr[1]), MODEW);
        check(log_t[1] - log_t[0] >= T_RP, "R3 tRP gap", log_t[1] - log_t[0], T_RP);
        // R4
        for (int i = 2; i < 10; i++) begin
            check(log_cmd[i] == REF, "R4 init refresh", int'(log_cmd[i]), int'(REF));
            check(log_t[i] - log_t[i-1] >= ((i == 2) ? T_MRD : T_RFC), "R4 spacing",
                  log_t[i] - log_t[i-1], (i == 2) ? T_MRD : T_RFC);
        end
        // R5
        check(log_cmd[10] == MRS && log_addr[10] == AW'(MODEW), "R5 second mode set",
              int'(log_addr[10]), MODEW);
        check(log_t[10] - log_t[9] >= T_RFC, "R5 spacing", log_t[10] - log_t[9], T_RFC);
        // R6
        check(log_cmd[11] == ACT && log_addr[11] == '0, "R6 activate row 0",
              int'(log_cmd[11]), int'(ACT));
        check(log_t[11] - log_t[10] >= T_MRD, "R6 tMRD", log_t[11] - log_t[10], T_MRD);
        for (int i = 0; i < 10; i++) begin
            idx = 12 + 2 * i;
            check(log_cmd[idx] == RD && log_addr[idx] == AW'(i), "R6 read column",
                  int'(log_addr[idx]), i);
            check(log_cmd[idx+1] == WR && log_addr[idx+1] == AW'(i), "R6 write column",
                  int'(log_addr[idx+1]), i);
            check(log_t[idx+1] - log_t[idx] >= CAS + 1, "R6 read-to-write",
                  log_t[idx+1] - log_t[idx], CAS + 1);
            check(log_t[idx] - log_t[idx-1] >= ((i == 0) ? T_RCD : T_WR), "R6 access gap",
                  log_t[idx] - log_t[idx-1], (i == 0) ? T_RCD : T_WR);
        end
        check(log_cmd[32] == PRE && log_addr[32][10], "R6 closing precharge-all",
              int'(log_cmd[32]), int'(PRE));
        // R7
        check(ready_t - log_t[32] >= T_RP, "R7 ready after tRP", ready_t - log_t[32], T_RP);
        check(ready_drop == 0, "R7 ready sticky", ready_drop, 0);
        // R8 / R9 refresh groups
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < 4; k++) begin
                idx = 33 + 4 * g + k;
                check(log_cmd[idx] == REF && log_t[idx] > ready_t, "R8 grouped refresh",
                      int'(log_cmd[idx]), int'(REF));
                if (k > 0)
                    check(log_t[idx] - log_t[idx-1] >= T_RFC, "R8 group spacing",
                          log_t[idx] - log_t[idx-1], T_RFC);
            end
        end
        for (int g = 1; g < 3; g++) begin
            check(log_t[33 + 4 * (g + 1)] - log_t[33 + 4 * g] == interval,
                  slow ? "R9 slow interval" : "R8 fast interval",
                  log_t[33 + 4 * (g + 1)] - log_t[33 + 4 * g], interval);
        end
        // R10: only legal codes were logged
        for (int i = 0; i < log_cnt; i++) begin
            if (!(log_cmd[i] inside {ACT, RD, WR, PRE, REF, MRS}))
                check(1'b0, "R10 legal code", int'(log_cmd[i]), int'(NOP));
        end
        check(1'b1, "R10 legal code", 0, 0);
    endtask

    initial begin
        run_phase(1'b0);
        run_phase(1'b1);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule